// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block translates one 64-bit virtual address into a real frame address by walking a hierarchy of in-memory translation tables. The hierarchy has up to three region levels, a segment level and a page level. A 64-bit address-space descriptor names the table the walk starts from and sets how deep that starting level is. For each level the walker reads one 8-byte entry through a simple memory read port. It then checks the entry and either moves one level down, stops early on a 1 MB large segment, or ends with a fault.

A request is accepted only while the walker is idle. The result is either a page-aligned real address with a write-permission flag, or a 4-bit fault code with a 64-bit exception word. The result stays on the outputs until the requester acknowledges it. Caching of translations and the delivery of the fault are done outside the block.

Descriptor layout: table origin in bits 63:12, real-space flag in bit 5, start type in bits 3:2 (0 segment, 1 region-third, 2 region-second, 3 region-first), length in bits 1:0. Fault codes: 0 none, 1 space-type, 2 region-first, 3 region-second, 4 region-third, 5 segment, 6 page, 7 specification, 8 protection.

Top module: `ptw_walker`

## Requirements
- R1: After reset `req_ready` is 1 and `res_valid` is 0. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` stays low from then on until the result has been acknowledged with `res_ack`. Until that acknowledge, the result outputs hold steady and no memory read is issued.
- R2: When descriptor bit 5 is set, the result is the virtual address with bits 11:0 cleared, writable 1 and fault 0, and no memory read is made.
- R3: The start type limits the address range. Type 2 faults with code 1 if any of virtual address bits 63:53 is set, type 1 if any of bits 63:42 is set, and type 0 if any of bits 63:31 is set. No read is made in these cases.
- R4: The 2-bit top index of the start level must not exceed the descriptor length. This index is at bits 63:62, 52:51, 41:40 or 30:29 for types 3, 2, 1 and 0. If it does, the walker raises that level's fault: code 2, 3, 4 or 5.
- R5: Each entry is read at the table origin plus 8 times the level index. The level indices are bits 63:53 (region-first), 52:42 (region-second), 41:31 (region-third), 30:20 (segment) and 19:12 (page). A region entry's bits 63:12 give the next table origin, and a segment entry's bits 63:11 give the page-table origin.
- R6: A region or segment entry with bit 5 set raises the fault of its own level (codes 2 to 5). If instead its type field, bits 3:2, differs from the level's type number, the walker raises code 7.
- R7: In a region entry, the 2-bit top index of the next level must lie between the entry's bits 7:6 and its bits 1:0, both inclusive. Otherwise the walker raises the next level's fault.
- R8: A segment entry with bit 10 set, while `large_frame_en` was 1 at the request, ends the walk without a page read. The result is entry bits 63:20 joined to virtual address bits 19:12, with 12 zero bits below.
- R9: A page entry with bit 10 set raises code 6. One with bit 8 set raises code 7. Otherwise the result is entry bits 63:12 with 12 zero bits.
- R10: Bit 9 of a page entry or a segment entry clears write permission. Bit 9 of a region entry does so only when `large_frame_en` is 1. A store whose walk ends without write permission raises code 8 instead of a result.
- R11: On a fault, `res_tec` is the virtual address with bits 11:0 cleared, ORed with 0x400 for a store or 0x800 otherwise, ORed with 4 for code 8, and ORed with `req_space` in bits 1:0. With no fault, `res_tec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 64 | Virtual address |
| req_desc | input | 64 | Address-space descriptor |
| req_store | input | 1 | Access is a store |
| req_space | input | 2 | Address-space mode reported in the exception word |
| large_frame_en | input | 1 | Enables large segments and region read-only bits |
| mem_rd_valid | output | 1 | One-cycle entry read request |
| mem_rd_addr | output | 64 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry contents |
| res_valid | output | 1 | Result present |
| res_ack | input | 1 | Result consumed |
| res_addr | output | 64 | Translated real address, page aligned |
| res_writable | output | 1 | Result may be stored to |
| res_fault | output | 4 | Fault code, 0 when none |
| res_tec | output | 64 | Translation-exception word |

## Verification
The bench builds a full five-level chain and then breaks it one field at a time. The breaks are an invalid bit, a wrong type, a next-level index just outside the offset/length window, and a reserved bit. It checks that each break gives the fault of the right level. A walker that charges the wrong level, or tests the window with the wrong bits, shows up as a wrong code. The large-segment and region read-only cases are run with the enable both on and off, which catches a walker that ignores the enable. Real-space and range faults are checked to make no memory reads. Held results are checked to stay steady while an extra request is offered.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int AW       = 64;
    localparam int PAGE_SH  = 12;
    localparam int IDX_W    = 11;
    localparam int PIDX_W   = 8;
    localparam int ENT_SH   = 3;

    typedef enum logic [3:0] {
        FLT_NONE  = 4'd0,
        FLT_SPACE = 4'd1,
        FLT_R1    = 4'd2,
        FLT_R2    = 4'd3,
        FLT_R3    = 4'd4,
        FLT_SEG   = 4'd5,
        FLT_PAGE  = 4'd6,
        FLT_SPEC  = 4'd7,
        FLT_PROT  = 4'd8
    } fault_e;

    typedef enum logic [2:0] {
        LV_PAGE = 3'd0,
        LV_SEG  = 3'd1,
        LV_R3   = 3'd2,
        LV_R2   = 3'd3,
        LV_R1   = 3'd4
    } level_e;

    typedef struct packed {
        fault_e          fault;
        logic            finish;
        logic            ro;
        level_e          next_lvl;
        logic [AW-1:0]   next_origin;
        logic [AW-1:0]   frame;
    } step_t;

    function automatic fault_e level_fault(level_e l);
        case (l)
            LV_R1:   return FLT_R1;
            LV_R2:   return FLT_R2;
            LV_R3:   return FLT_R3;
            LV_SEG:  return FLT_SEG;
            LV_PAGE: return FLT_PAGE;
            default: return FLT_SPEC;
        endcase
    endfunction

    // 2-bit top index of a table level (segment and above)
    function automatic logic [1:0] top_index(level_e l, logic [AW-1:0] va);
        return 2'(va >> (18 + 11 * int'(l)));
    endfunction

    // byte offset of the entry selected at level l
    function automatic logic [AW-1:0] entry_offset(level_e l, logic [AW-1:0] va);
        logic [IDX_W-1:0] idx;
        if (l == LV_PAGE) begin
            return AW'({va[PAGE_SH+PIDX_W-1:PAGE_SH], 3'b000});
        end
        idx = IDX_W'(va >> (9 + 11 * int'(l)));
        return AW'({idx, 3'b000});
    endfunction

    function automatic logic [AW-1:0] make_tec(logic [AW-1:0] va, logic store,
                                               logic prot, logic [1:0] space);
        logic [AW-1:0] w;
        w = {va[AW-1:PAGE_SH], {PAGE_SH{1'b0}}};
        w = w | (store ? AW'(12'h400) : AW'(12'h800));
        if (prot) w = w | AW'(3'd4);
        return w | AW'(space);
    endfunction

endpackage

// File: rtl/ptw_range_check.sv
module ptw_range_check
    import ptw_pkg::*;
(
    input  logic [AW-1:0] va,
    input  logic [AW-1:0] desc,
    output level_e        start_lvl,
    output fault_e        start_fault
);
    logic [1:0] len;
    logic       out_of_space;

    always_comb begin
        start_lvl = level_e'(3'(desc[3:2]) + 3'd1);
        len       = desc[1:0];
        case (start_lvl)
            LV_R2:   out_of_space = |va[63:53];
            LV_R3:   out_of_space = |va[63:42];
            LV_SEG:  out_of_space = |va[63:31];
            default: out_of_space = 1'b0;
        endcase
        if (out_of_space)
            start_fault = FLT_SPACE;
        else if (top_index(start_lvl, va) > len)
            start_fault = level_fault(start_lvl);
        else
            start_fault = FLT_NONE;
    end
endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
    import ptw_pkg::*;
(
    input  level_e        lvl,
    input  logic [AW-1:0] entry,
    input  logic [AW-1:0] va,
    input  logic          large_en,
    output step_t         step
);
    level_e     nl;
    logic [1:0] ni;

    always_comb begin
        step = '{fault: FLT_NONE, finish: 1'b0, ro: 1'b0, next_lvl: LV_PAGE,
                 next_origin: '0, frame: '0};
        nl = level_e'(lvl - 3'd1);
        ni = top_index(nl, va);
        if (lvl == LV_PAGE) begin
            if (entry[10])
                step.fault = FLT_PAGE;
            else if (entry[8])
                step.fault = FLT_SPEC;
            else begin
                step.finish = 1'b1;
                step.ro     = entry[9];
                step.frame  = {entry[AW-1:PAGE_SH], {PAGE_SH{1'b0}}};
            end
        end else if (entry[5]) begin
            step.fault = level_fault(lvl);
        end else if (3'(entry[3:2]) != 3'(lvl - 3'd1)) begin
            step.fault = FLT_SPEC;
        end else if (lvl == LV_SEG) begin
            step.ro = entry[9];
            if (entry[10] && large_en) begin
                step.finish = 1'b1;
                step.frame  = {entry[AW-1:20], va[19:PAGE_SH], {PAGE_SH{1'b0}}};
            end else begin
                step.next_lvl    = LV_PAGE;
                step.next_origin = {entry[AW-1:11], 11'b0};
            end
        end else begin
            if (ni < entry[7:6] || ni > entry[1:0]) begin
                step.fault = level_fault(nl);
            end else begin
                step.ro          = large_en & entry[9];
                step.next_lvl    = nl;
                step.next_origin = {entry[AW-1:PAGE_SH], {PAGE_SH{1'b0}}};
            end
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [63:0]   req_vaddr,
    input  logic [63:0]   req_desc,
    input  logic          req_store,
    input  logic [1:0]    req_space,
    input  logic          large_frame_en,
    output logic          mem_rd_valid,
    output logic [63:0]   mem_rd_addr,
    input  logic          mem_rsp_valid,
    input  logic [63:0]   mem_rsp_data,
    output logic          res_valid,
    input  logic          res_ack,
    output logic [63:0]   res_addr,
    output logic          res_writable,
    output logic [3:0]    res_fault,
    output logic [63:0]   res_tec
);
    typedef enum logic [1:0] {S_IDLE, S_READ, S_WAIT, S_DONE} state_e;

    state_e        state;
    logic [AW-1:0] va_q, origin_q;
    logic          store_q, large_q, wr_q;
    logic [1:0]    space_q;
    level_e        lvl_q;

    logic [AW-1:0] va_pg;
    level_e        start_lvl;
    fault_e        start_fault;
    step_t         step;

    logic          fin;
    fault_e        fin_fault;
    logic [AW-1:0] fin_addr;
    logic          fin_wr;
    logic [AW-1:0] t_va;
    logic          t_store;
    logic [1:0]    t_space;
    logic          wr_next;

    assign va_pg = {req_vaddr[AW-1:PAGE_SH], {PAGE_SH{1'b0}}};

    ptw_range_check u_range (
        .va          (va_pg),
        .desc        (req_desc),
        .start_lvl   (start_lvl),
        .start_fault (start_fault)
    );

    ptw_entry_eval u_eval (
        .lvl      (lvl_q),
        .entry    (mem_rsp_data),
        .va       (va_q),
        .large_en (large_q),
        .step     (step)
    );

    assign req_ready    = (state == S_IDLE);
    assign mem_rd_valid = (state == S_READ);
    assign mem_rd_addr  = origin_q + entry_offset(lvl_q, va_q);
    assign wr_next      = wr_q & ~step.ro;

    always_comb begin
        fin       = 1'b0;
        fin_fault = FLT_NONE;
        fin_addr  = '0;
        fin_wr    = 1'b0;
        t_va      = va_q;
        t_store   = store_q;
        t_space   = space_q;
        if (state == S_IDLE) begin
            t_va    = va_pg;
            t_store = req_store;
            t_space = req_space;
            if (req_valid) begin
                if (req_desc[5]) begin
                    fin      = 1'b1;
                    fin_addr = va_pg;
                    fin_wr   = 1'b1;
                end else if (start_fault != FLT_NONE) begin
                    fin       = 1'b1;
                    fin_fault = start_fault;
                end
            end
        end else if (state == S_WAIT && mem_rsp_valid) begin
            if (step.fault != FLT_NONE) begin
                fin       = 1'b1;
                fin_fault = step.fault;
            end else if (step.finish) begin
                fin = 1'b1;
                if (store_q && !wr_next) begin
                    fin_fault = FLT_PROT;
                end else begin
                    fin_addr = step.frame;
                    fin_wr   = wr_next;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= S_IDLE;
            res_valid    <= 1'b0;
            res_addr     <= '0;
            res_writable <= 1'b0;
            res_fault    <= 4'd0;
            res_tec      <= '0;
            va_q         <= '0;
            origin_q     <= '0;
            store_q      <= 1'b0;
            large_q      <= 1'b0;
            wr_q         <= 1'b0;
            space_q      <= 2'd0;
            lvl_q        <= LV_PAGE;
        end else begin
            if (state == S_IDLE && req_valid) begin
                va_q      <= va_pg;
                store_q   <= req_store;
                space_q   <= req_space;
                large_q   <= large_frame_en;
                wr_q      <= 1'b1;
                lvl_q     <= start_lvl;
                origin_q  <= {req_desc[AW-1:PAGE_SH], {PAGE_SH{1'b0}}};
                if (!fin) state <= S_READ;
            end
            if (state == S_READ) state <= S_WAIT;
            if (state == S_WAIT && mem_rsp_valid && !fin) begin
                lvl_q    <= step.next_lvl;
                origin_q <= step.next_origin;
                wr_q     <= wr_next;
                state    <= S_READ;
            end
            if (fin) begin
                state        <= S_DONE;
                res_valid    <= 1'b1;
                res_addr     <= fin_addr;
                res_writable <= fin_wr;
                res_fault    <= fin_fault;
                res_tec      <= (fin_fault == FLT_NONE) ? '0 :
                                make_tec(t_va, t_store, fin_fault == FLT_PROT, t_space);
            end
            if (state == S_DONE && res_ack) begin
                state     <= S_IDLE;
                res_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ptw_walker_check.sv
module ptw_walker_check (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        mem_rd_valid,
    input logic        res_valid,
    input logic        res_ack,
    input logic [63:0] res_addr,
    input logic        res_writable,
    input logic [3:0]  res_fault,
    input logic [63:0] res_tec
);
    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        res_valid && !res_ack |=> res_valid && $stable(res_addr) &&
        $stable(res_fault) && $stable(res_tec) && $stable(res_writable));

    a_r1_busy: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !req_ready);

    a_r1_no_read_idle: assert property (@(posedge clk) disable iff (rst)
        (req_ready || res_valid) |-> !mem_rd_valid);

    a_r5_single_read: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |=> !mem_rd_valid);

    a_r11_tec_clear: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_fault == 4'd0 |-> res_tec == 64'd0);

    a_r11_tec_kind: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_fault != 4'd0 |-> (res_tec[11] ^ res_tec[10]));

    a_r10_prot_word: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_fault == 4'd8 |-> res_tec[2] && res_tec[10] && !res_writable);

    a_r9_aligned: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> res_addr[11:0] == 12'd0);
endmodule

bind ptw_walker ptw_walker_check u_ptw_walker_check (
    .clk          (clk),
    .rst          (rst),
    .req_ready    (req_ready),
    .mem_rd_valid (mem_rd_valid),
    .res_valid    (res_valid),
    .res_ack      (res_ack),
    .res_addr     (res_addr),
    .res_writable (res_writable),
    .res_fault    (res_fault),
    .res_tec      (res_tec)
);

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [63:0] req_desc = '0;
    logic        req_store = 1'b0;
    logic [1:0]  req_space = 2'd0;
    logic        large_frame_en = 1'b0;
    logic        mem_rd_valid;
    logic [63:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        res_valid;
    logic        res_ack = 1'b0;
    logic [63:0] res_addr;
    logic        res_writable;
    logic [3:0]  res_fault;
    logic [63:0] res_tec;

    int n_tests = 0;
    int n_fail  = 0;
    int n_reads = 0;
    bit done    = 0;

    logic [63:0] mem [logic [63:0]];

    // captured result
    logic [63:0] g_addr, g_tec;
    logic        g_wr;
    logic [3:0]  g_fault;
    int          g_reads;

    always #2 clk = ~clk;

    ptw_walker i_ptw_walker (.*);

    always @(posedge clk) begin
        mem_rsp_valid <= mem_rd_valid;
        if (mem_rd_valid) begin
            mem_rsp_data <= mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 64'd0;
            n_reads <= n_reads + 1;
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    localparam logic [63:0] T1 = 64'h10000, T2 = 64'h20000, T3 = 64'h30000,
                            T4 = 64'h40000, T5 = 64'h50800;

    function automatic logic [63:0] mkva(int a, int b, int c, int d, int p);
        return {11'(a), 11'(b), 11'(c), 11'(d), 8'(p), 12'habc};
    endfunction
    function automatic logic [63:0] a1(logic [63:0] v); return T1 + {v[63:53], 3'b0}; endfunction
    function automatic logic [63:0] a2(logic [63:0] v); return T2 + {v[52:42], 3'b0}; endfunction
    function automatic logic [63:0] a3(logic [63:0] v); return T3 + {v[41:31], 3'b0}; endfunction
    function automatic logic [63:0] a4(logic [63:0] v); return T4 + {v[30:20], 3'b0}; endfunction
    function automatic logic [63:0] a5(logic [63:0] v); return T5 + {v[19:12], 3'b0}; endfunction

    localparam logic [63:0] DESC_R1 = T1 | 64'hF; // type 3, length 3
    localparam logic [63:0] FRAME   = 64'h777000;

    task automatic build(logic [63:0] v);
        mem.delete();
        mem[a1(v)] = T2 | 64'h0F;   // type 3, TF 0, TL 3
        mem[a2(v)] = T3 | 64'h0B;   // type 2
        mem[a3(v)] = T4 | 64'h07;   // type 1
        mem[a4(v)] = T5;            // segment, type 0
        mem[a5(v)] = FRAME;
    endtask

    task automatic run(logic [63:0] v, logic [63:0] d, logic st, logic [1:0] sp, logic lg);
        int base;
        int guard;
        @(negedge clk);
        base = n_reads;
        req_vaddr = v; req_desc = d; req_store = st; req_space = sp; large_frame_en = lg;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!res_valid && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        g_addr = res_addr; g_tec = res_tec; g_wr = res_writable; g_fault = res_fault;
        g_reads = n_reads - base;
        res_ack = 1'b1;
        @(negedge clk);
        res_ack = 1'b0;
    endtask

    function automatic logic [63:0] pg(logic [63:0] v); return {v[63:12], 12'b0}; endfunction

    task automatic t_reset;
        chk("R1 reset ready", 64'(req_ready), 64'd1);
        chk("R1 reset valid", 64'(res_valid), 64'd0);
    endtask

    task automatic t_real;
        logic [63:0] v = 64'h1234_5678_9ABC_DEF0;
        run(v, 64'h20 | 64'hF, 1'b1, 2'd0, 1'b0);
        chk("R2 addr", g_addr, 64'h1234_5678_9ABC_D000);
        chk("R2 fault", 64'(g_fault), 64'd0);
        chk("R2 writable", 64'(g_wr), 64'd1);
        chk("R2 no reads", 64'(g_reads), 64'd0);
    endtask

    task automatic t_range;
        run(64'h0020_0000_0000_0000, T1 | 64'hB, 1'b0, 2'd0, 1'b0);
        chk("R3 type2 bit53", 64'(g_fault), 64'd1);
        chk("R3 no reads", 64'(g_reads), 64'd0);
        run(64'h0000_0400_0000_0000, T1 | 64'h7, 1'b0, 2'd0, 1'b0);
        chk("R3 type1 bit42", 64'(g_fault), 64'd1);
        run(64'h0000_0000_8000_0000, T1 | 64'h3, 1'b0, 2'd0, 1'b0);
        chk("R3 type0 bit31", 64'(g_fault), 64'd1);
    endtask

    task automatic t_length;
        run(64'h8000_0000_0000_0000, T1 | 64'hD, 1'b0, 2'd0, 1'b0);
        chk("R4 type3 len1", 64'(g_fault), 64'd2);
        run(64'h0000_0000_2000_0000, T1 | 64'h0, 1'b0, 2'd0, 1'b0);
        chk("R4 type0 len0", 64'(g_fault), 64'd5);
        chk("R4 no reads", 64'(g_reads), 64'd0);
    endtask

    task automatic t_walk;
        logic [63:0] v = mkva(1, 2, 3, 4, 5);
        build(v);
        run(v, DESC_R1, 1'b1, 2'd0, 1'b0);
        chk("R5 five-level addr", g_addr, FRAME);
        chk("R5 fault", 64'(g_fault), 64'd0);
        chk("R5 reads", 64'(g_reads), 64'd5);
        chk("R10 writable", 64'(g_wr), 64'd1);
        chk("R11 tec zero", g_tec, 64'd0);
    endtask

    task automatic t_invalid_type;
        logic [63:0] v = mkva(1, 2, 3, 4, 5);
        build(v);
        mem[a3(v)] = T4 | 64'h27;
        run(v, DESC_R1, 1'b0, 2'd0, 1'b0);
        chk("R6 region3 invalid", 64'(g_fault), 64'd4);
        build(v);
        mem[a4(v)] = T5 | 64'h20;
        run(v, DESC_R1, 1'b0, 2'd0, 1'b0);
        chk("R6 segment invalid", 64'(g_fault), 64'd5);
        build(v);
        mem[a2(v)] = T3 | 64'h07;
        run(v, DESC_R1, 1'b0, 2'd0, 1'b0);
        chk("R6 type mismatch", 64'(g_fault), 64'd7);
    endtask

    task automatic t_window;
        logic [63:0] v = mkva(1, 2, 3, 4, 5);
        logic [63:0] w = mkva(1, 11'h602, 3, 4, 5);
        build(v);
        mem[a1(v)] = T2 | 64'h4F;   // TF 1, index 0
        run(v, DESC_R1, 1'b0, 2'd0, 1'b0);
        chk("R7 below offset", 64'(g_fault), 64'd3);
        build(w);
        mem[a1(w)] = T2 | 64'h0E;   // TL 2, index 3
        run(w, DESC_R1, 1'b0, 2'd0, 1'b0);
        chk("R7 above length", 64'(g_fault), 64'd3);
        build(w);
        mem[a1(w)] = T2 | 64'hCF;   // TF 3, TL 3, index 3
        run(w, DESC_R1, 1'b0, 2'd0, 1'b0);
        chk("R7 window edge", g_addr, FRAME);
        build(v);
        mem[a2(v)] = T3 | 64'h0A;   // R3 top index = v[41:40] = 0 in TL 2: ok
        mem[a3(v)] = T4 | 64'h44;   // TF 1 vs segment index top v[30:29] = 0
        run(v, DESC_R1, 1'b0, 2'd0, 1'b0);
        chk("R7 next is segment", 64'(g_fault), 64'd5);
    endtask

    task automatic t_large;
        logic [63:0] v = mkva(1, 2, 3, 4, 5);
        build(v);
        mem[a4(v)] = 64'h1230_0000 | 64'h400;
        run(v, DESC_R1, 1'b0, 2'd0, 1'b1);
        chk("R8 large addr", g_addr, 64'h1230_5000);
        chk("R8 no page read", 64'(g_reads), 64'd4);
        run(v, DESC_R1, 1'b0, 2'd0, 1'b0);
        chk("R8 disabled reads page", 64'(g_reads), 64'd5);
        chk("R8 disabled addr", g_addr, 64'd0);
    endtask

    task automatic t_page;
        logic [63:0] v = mkva(1, 2, 3, 4, 5);
        build(v);
        mem[a5(v)] = FRAME | 64'h400;
        run(v, DESC_R1, 1'b0, 2'd2, 1'b0);
        chk("R9 page invalid", 64'(g_fault), 64'd6);
        chk("R11 read word", g_tec, pg(v) | 64'h800 | 64'h2);
        mem[a5(v)] = FRAME | 64'h100;
        run(v, DESC_R1, 1'b0, 2'd0, 1'b0);
        chk("R9 reserved bit", 64'(g_fault), 64'd7);
    endtask

    task automatic t_ro;
        logic [63:0] v = mkva(1, 2, 3, 4, 5);
        build(v);
        mem[a5(v)] = FRAME | 64'h200;
        run(v, DESC_R1, 1'b1, 2'd3, 1'b0);
        chk("R10 page ro store", 64'(g_fault), 64'd8);
        chk("R11 prot word", g_tec, pg(v) | 64'h400 | 64'h4 | 64'h3);
        run(v, DESC_R1, 1'b0, 2'd0, 1'b0);
        chk("R10 page ro load ok", g_addr, FRAME);
        chk("R10 page ro not writable", 64'(g_wr), 64'd0);
        build(v);
        mem[a4(v)] = T5 | 64'h200;
        run(v, DESC_R1, 1'b1, 2'd0, 1'b0);
        chk("R10 segment ro store", 64'(g_fault), 64'd8);
        build(v);
        mem[a2(v)] = T3 | 64'h20B;
        run(v, DESC_R1, 1'b1, 2'd0, 1'b0);
        chk("R10 region ro ignored", 64'(g_fault), 64'd0);
        chk("R10 region ro ignored wr", 64'(g_wr), 64'd1);
        run(v, DESC_R1, 1'b1, 2'd0, 1'b1);
        chk("R10 region ro honoured", 64'(g_fault), 64'd8);
    endtask

    task automatic t_store_word;
        logic [63:0] v = mkva(1, 2, 3, 4, 5);
        build(v);
        mem[a3(v)] = T4 | 64'h27;
        run(v, DESC_R1, 1'b1, 2'd1, 1'b0);
        chk("R11 store word", g_tec, pg(v) | 64'h400 | 64'h1);
    endtask

    task automatic t_hold;
        logic [63:0] v = 64'h0000_0000_0000_5000;
        logic [63:0] a0;
        int base;
        @(negedge clk);
        req_vaddr = v; req_desc = 64'h20; req_store = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        chk("R1 result ready", 64'(res_valid), 64'd1);
        a0 = res_addr;
        base = n_reads;
        req_vaddr = 64'h9000;   // extra request offered while busy
        repeat (3) @(negedge clk);
        chk("R1 held valid", 64'(res_valid), 64'd1);
        chk("R1 held addr", res_addr, a0);
        chk("R1 busy", 64'(req_ready), 64'd0);
        chk("R1 no read while held", 64'(n_reads - base), 64'd0);
        req_valid = 1'b0;
        res_ack = 1'b1;
        @(negedge clk);
        res_ack = 1'b0;
        chk("R1 released", 64'(res_valid), 64'd0);
        chk("R1 ready again", 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_real();
        t_range();
        t_length();
        t_walk();
        t_invalid_type();
        t_window();
        t_large();
        t_page();
        t_ro();
        t_store_word();
        t_hold();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule